// File: doc/BRIEF.md
# Receive Payload Ones'-Complement Checksum

This block watches a byte-wide stream of received Ethernet frames and builds a 16-bit ones'-complement sum over the frame payload. The payload is every byte after the 14-byte MAC header (destination, source and type). It stops before the 4-byte frame check sequence at the tail. Bytes are taken two at a time. In each pair the later byte is the high octet. A lone final byte is padded with a zero high octet. Every carry out of the 16-bit adder is folded back into the sum.

The end-of-frame marker comes with the last check-sequence byte, so the block cannot tell in advance where the payload ends. It therefore passes each accepted byte through a four-position delay line and sums only the bytes leaving that line. When the frame ends, the four bytes still in the line are thrown away. The result, a short-frame flag and a one-cycle done strobe appear the cycle after the final byte is accepted. The result and flag then hold until the next frame ends.

Top module: `rxpl_csum_top`

## Requirements
- R1: After reset `out_done`, `out_short` and `out_sum` are all zero.
- R2: The sum starts at frame byte index 14, where byte 0 carries `in_sof`. Payload bytes are paired in arrival order, and each pair contributes the 16-bit word second_byte*256 + first_byte.
- R3: A carry out of bit 15 in any addition is added back into bit 0 (end-around carry). For example, words 0x8000 and 0x8000 give 0x0001.
- R4: With an odd payload length, the final payload byte contributes the word 0x00nn, where nn is that byte.
- R5: The last four bytes of a frame, ending with the byte that carries `in_eof`, never change the result.
- R6: `out_done` is high for exactly the cycle after the byte carrying `in_eof` is accepted. `out_sum` and `out_short` update in that same cycle and then hold until the next done.
- R7: A frame of fewer than 18 bytes gives `out_sum` = 0 with `out_short` = 1. A frame of exactly 18 bytes gives `out_sum` = 0 with `out_short` = 0.
- R8: A byte with `in_sof` restarts the sum, even inside an unfinished frame. The unfinished frame gives no done.
- R9: A cycle with `in_valid` low is ignored, whatever `in_sof`, `in_eof` and `in_byte` carry. A valid byte that arrives after a frame's end and before the next `in_sof` is also ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A byte is present this cycle |
| in_sof | input | 1 | This byte is byte 0 of a frame |
| in_eof | input | 1 | This byte is the last byte of a frame |
| in_byte | input | 8 | Frame byte |
| out_sum | output | 16 | Payload ones'-complement sum of the last finished frame |
| out_done | output | 1 | One-cycle strobe that a frame has finished |
| out_short | output | 1 | The last finished frame was under 18 bytes |

## Verification
The assertions assume that `in_sof` and `in_eof` only matter while `in_valid` is high. They also assume that a frame's end is the accepted byte carrying `in_eof`, with nothing implied about bytes outside a frame. The stimulus always drives markers on valid bytes for real frames. During idle gaps it deliberately raises `in_sof` and `in_eof` with `in_valid` low, and it injects stray valid bytes between frames, to show that these are ignored. Frame lengths stay far below the 12-bit byte-count saturation point, so the count never wraps within a frame.

// File: rtl/rxpl_csum_pkg.sv
package rxpl_csum_pkg;

    typedef struct packed {
        logic [15:0] sum;
        logic [7:0]  lo;
        logic        lo_v;
    } acc_state_t;

    function automatic logic [15:0] add1c(input logic [15:0] a, input logic [15:0] b);
        logic [16:0] t;
        t = {1'b0, a} + {1'b0, b};
        return t[15:0] + {15'd0, t[16]};
    endfunction

endpackage

// File: rtl/rxpl_trail_delay.sv
module rxpl_trail_delay #(
    parameter int DEPTH = 4,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                stage[g] <= '0;
            end else if (shift) begin
                if (g == 0) stage[g] <= din;
                else        stage[g] <= stage[g-1];
            end
        end
    end

    assign dout = stage[DEPTH-1];

    // R5
    first_stage_load_chk: assert property (@(posedge clk) disable iff (rst)
        shift |=> stage[0] == $past(din));
endmodule

// File: rtl/rxpl_pair_acc.sv
module rxpl_pair_acc
    import rxpl_csum_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clear,
    input  logic        take,
    input  logic [7:0]  din,
    output logic [15:0] fin_sum
);
    acc_state_t st, nxt;

    always_comb begin
        nxt = st;
        if (clear) begin
            nxt = '0;
        end else if (take) begin
            if (st.lo_v) begin
                nxt.sum  = add1c(st.sum, {din, st.lo});
                nxt.lo_v = 1'b0;
            end else begin
                nxt.lo   = din;
                nxt.lo_v = 1'b1;
            end
        end
        fin_sum = nxt.lo_v ? add1c(nxt.sum, {8'h00, nxt.lo}) : nxt.sum;
    end

    always_ff @(posedge clk) begin
        if (rst) st <= '0;
        else     st <= nxt;
    end

    // R4
    lone_byte_pending_chk: assert property (@(posedge clk) disable iff (rst)
        (take && !clear && !st.lo_v) |=> st.lo_v);

    // R8
    restart_empty_chk: assert property (@(posedge clk) disable iff (rst)
        clear |=> (st.sum == 16'd0 && !st.lo_v));
endmodule

// File: rtl/rxpl_csum_top.sv
module rxpl_csum_top
    import rxpl_csum_pkg::*;
#(
    parameter int HDR_LEN   = 14,
    parameter int TRAIL_LEN = 4,
    parameter int LEN_W     = 12
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic        in_sof,
    input  logic        in_eof,
    input  logic [7:0]  in_byte,
    output logic [15:0] out_sum,
    output logic        out_done,
    output logic        out_short
);
    localparam int MIN_LEN = HDR_LEN + TRAIL_LEN;
    localparam logic [LEN_W-1:0] IDX_MAX = '1;
    localparam logic [LEN_W-1:0] TAKE_AT = LEN_W'(MIN_LEN);
    localparam logic [LEN_W-1:0] SHORT_BELOW = LEN_W'(MIN_LEN - 1);

    logic             in_frame;
    logic [LEN_W-1:0] idx, idx_now;
    logic             accept, take, short_now, end_acc;
    logic [7:0]       dly_out;
    logic [15:0]      fin_sum;

    assign accept    = in_valid && (in_sof || in_frame);
    assign idx_now   = in_sof ? '0 : idx;
    assign take      = accept && (idx_now >= TAKE_AT);
    assign short_now = idx_now < SHORT_BELOW;
    assign end_acc   = accept && in_eof;

    rxpl_trail_delay #(.DEPTH(TRAIL_LEN), .W(8)) i_delay (
        .clk(clk), .rst(rst), .shift(accept), .din(in_byte), .dout(dly_out)
    );

    rxpl_pair_acc i_acc (
        .clk(clk), .rst(rst), .clear(accept && in_sof), .take(take),
        .din(dly_out), .fin_sum(fin_sum)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            in_frame  <= 1'b0;
            idx       <= '0;
            out_sum   <= '0;
            out_done  <= 1'b0;
            out_short <= 1'b0;
        end else begin
            out_done <= end_acc;
            if (accept) begin
                in_frame <= !in_eof;
                idx      <= (idx_now == IDX_MAX) ? IDX_MAX : idx_now + 1'b1;
            end
            if (end_acc) begin
                out_sum   <= short_now ? 16'd0 : fin_sum;
                out_short <= short_now;
            end
        end
    end

    // R6
    done_follows_end_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (in_sof || in_frame) && in_eof) |=> out_done);

    // R6
    no_spurious_done_chk: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && (in_sof || in_frame) && in_eof) |=> !out_done);

    // R6
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !out_done |-> ($stable(out_sum) && $stable(out_short)));

    // R7
    short_zero_chk: assert property (@(posedge clk) disable iff (rst)
        out_short |-> (out_sum == 16'd0));
endmodule

// File: tb/test_rxpl_csum_top.sv
module test_rxpl_csum_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic [15:0] out_sum;
    logic        out_done, out_short;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] fr [0:255];

    always #4 clk = ~clk;

    rxpl_csum_top i_rxpl_csum_top (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof),
        .in_eof(in_eof), .in_byte(in_byte), .out_sum(out_sum),
        .out_done(out_done), .out_short(out_short)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] fold(input logic [15:0] a, input logic [15:0] b);
        logic [16:0] t;
        t = {1'b0, a} + {1'b0, b};
        return t[15:0] + {15'd0, t[16]};
    endfunction

    function automatic logic [15:0] model(input int n);
        logic [15:0] s = 16'd0;
        if (n < 18) return 16'd0;
        for (int i = 14; i <= n - 5; i += 2) begin
            if (i + 1 <= n - 5) s = fold(s, {fr[i+1], fr[i]});
            else                s = fold(s, {8'h00, fr[i]});
        end
        return s;
    endfunction

    task automatic idle(input int k);
        for (int j = 0; j < k; j++) begin
            @(negedge clk);
            in_valid = 1'b0; in_sof = 1'b1; in_eof = 1'b1; in_byte = 8'hEE;
        end
    endtask

    task automatic drive(input int n, input bit with_eof, input bit gaps);
        for (int i = 0; i < n; i++) begin
            if (gaps && (i % 3 == 1)) idle(1);
            @(negedge clk);
            in_valid = 1'b1; in_sof = (i == 0); in_eof = with_eof && (i == n - 1);
            in_byte = fr[i];
        end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    endtask

    task automatic send(input string req, input int n, input bit gaps);
        logic [15:0] exp;
        exp = model(n);
        drive(n, 1'b1, gaps);
        check({req, " done"}, out_done, 1);
        check({req, " sum"}, out_sum, exp);
        check({req, " short"}, out_short, (n < 18));
        @(negedge clk);
        check({req, " done width"}, out_done, 0);
    endtask

    task automatic t_reset;
        check("R1 done", out_done, 0);
        check("R1 sum", out_sum, 0);
        check("R1 short", out_short, 0);
    endtask

    task automatic t_basic;
        for (int i = 0; i < 64; i++) fr[i] = 8'(i * 7 + 3);
        send("R2 basic", 64, 0);
        for (int i = 0; i < 14; i++) fr[i] = 8'hFF;
        for (int i = 14; i < 40; i++) fr[i] = 8'(i * 29 + 11);
        send("R2 header", 40, 0);
    endtask

    task automatic t_carry;
        for (int i = 0; i < 22; i++) fr[i] = 8'h00;
        fr[15] = 8'h80; fr[17] = 8'h80;
        send("R3 carry", 22, 0);
        check("R3 literal", out_sum, 16'h0001);
        for (int i = 0; i < 30; i++) fr[i] = 8'hFF;
        send("R3 allones", 30, 0);
    endtask

    task automatic t_odd;
        for (int i = 0; i < 21; i++) fr[i] = 8'h55;
        fr[14] = 8'h12; fr[15] = 8'h34; fr[16] = 8'hAB;
        send("R4 odd", 21, 0);
        check("R4 literal", out_sum, 16'h34BD);
        fr[14] = 8'h9C;
        send("R4 single", 19, 0);
        check("R4 single literal", out_sum, 16'h009C);
    endtask

    task automatic t_fcs;
        for (int i = 0; i < 22; i++) fr[i] = (i < 18) ? 8'h00 : 8'hFF;
        send("R5 trailer", 22, 0);
        check("R5 literal", out_sum, 16'h0000);
    endtask

    task automatic t_short;
        for (int i = 0; i < 20; i++) fr[i] = 8'h77;
        send("R7 len17", 17, 0);
        send("R7 len1", 1, 0);
        send("R7 len18", 18, 0);
        check("R7 len18 short", out_short, 0);
    endtask

    task automatic t_gaps;
        for (int i = 0; i < 50; i++) fr[i] = 8'(i * 13 + 5);
        send("R9 gaps", 50, 1);
        @(negedge clk);
        in_valid = 1'b1; in_sof = 1'b0; in_eof = 1'b1; in_byte = 8'hA5;
        @(negedge clk);
        in_valid = 1'b0; in_eof = 1'b0;
        check("R9 stray no done", out_done, 0);
        for (int i = 0; i < 30; i++) fr[i] = 8'(i * 3 + 1);
        send("R9 after stray", 30, 0);
    endtask

    task automatic t_restart;
        logic [15:0] held;
        for (int i = 0; i < 40; i++) fr[i] = 8'hC3;
        drive(30, 1'b0, 0);
        check("R8 no done", out_done, 0);
        for (int i = 0; i < 36; i++) fr[i] = 8'(i * 5 + 9);
        send("R8 restart", 36, 0);
        held = out_sum;
        idle(5);
        check("R6 hold", out_sum, held);
        check("R6 hold done", out_done, 0);
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_carry();
        t_odd();
        t_fcs();
        t_short();
        t_gaps();
        t_restart();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule